// File: doc/BRIEF.md
# Two-Way Set-Associative Data Cache Controller

This block is a data cache between a processor-side word port and a main-memory port. Each address has three fields. The tag is in the upper bits, the set index is in the middle bits and the byte offset is in the low two bits. Every set holds two 32-bit lines, and each line holds one 4-byte block. A lookup compares the tag against both valid ways of the indexed set. A miss reads the whole block from memory into a chosen way and then answers the processor from that line. Each line carries a recency (USE) bit, and the way that was not recently used is the one evicted.

Two mode inputs are sampled with each request. The write-policy input selects write-back when high and write-through when low. In write-back mode each line has an update (dirty) bit. The bypass input sends an access straight to memory, with no lookup and no allocation. There are two maintenance commands. The discard command clears every valid bit in one cycle and writes nothing to memory. The clean-and-discard command walks every line, writes out each valid dirty one, and then clears all valid bits.

The processor presents a request while `ready_o` is high. The result comes back as a one-cycle `ack_o` pulse. For reads the data is on `rdata_o` during that pulse. The memory port holds a request until the memory acknowledges it.

Top module: `cache2w_ctrl`

## Requirements
- R1: The block address is `addr_i[ADDR_W-1:2]`. The set index is its low SET_W bits and the tag is the rest. The two byte-offset bits do not affect lookup, so two addresses that differ only in those bits reach the same line.
- R2: A block resides only in set (block mod 2^SET_W), in either of two ways. Two blocks of one set with different tags are resident at the same time.
- R3: A read hit returns the cached word with `ack_o` high for exactly one cycle and causes no memory request.
- R4: A read miss issues one memory read of the block address (`mem_addr_o` = `addr_i[ADDR_W-1:2]`), fills the line and returns the memory word. A memory request is held stable until it is acknowledged.
- R5: On a miss with both ways valid, the way whose USE bit is clear is evicted. Every hit or fill sets the USE bit of the accessed way and clears the USE bit of the other way in the set.
- R6: In write-back mode (`nwt_i`=1), a write hit updates only the cache and sets the line's dirty bit. An evicted line is written to memory only if it is dirty.
- R7: In write-through mode (`nwt_i`=0), every write issues a memory write. A write hit also updates the cached word.
- R8: With `cd_i`=1, an access goes directly to memory. It performs no lookup, so a read returns the memory word even if the cache holds newer data, and it performs no allocation.
- R9: A pulse on `inv_i` while idle clears all valid bits without any memory write. Dirty data is lost.
- R10: A pulse on `flush_i` while idle writes every valid dirty line to memory and then clears all valid bits.
- R11: A write-back write miss fetches the block, merges the write and marks the line dirty. A write-through write miss writes memory only and does not allocate.
- R12: After reset, `ready_o` is 1 and `mem_req_o` is 0. `ready_o` stays 0 while an access or a maintenance command is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Processor access request, taken when ready_o is 1 |
| we_i | input | 1 | 1 for a write, 0 for a read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | DATA_W | Write word |
| nwt_i | input | 1 | Write policy: 1 selects write-back, 0 selects write-through |
| cd_i | input | 1 | Bypass the cache for this access |
| inv_i | input | 1 | Discard all lines |
| flush_i | input | 1 | Write back dirty lines, then discard all lines |
| ready_o | output | 1 | Idle; ready to accept a request or command |
| ack_o | output | 1 | One-cycle pulse when an access completes |
| rdata_o | output | DATA_W | Read word, valid while ack_o is 1 |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | Memory write when 1 |
| mem_addr_o | output | ADDR_W-2 | Memory block address |
| mem_wdata_o | output | DATA_W | Memory write word |
| mem_rdata_i | input | DATA_W | Memory read word, valid with mem_ack_i |
| mem_ack_i | input | 1 | Memory acknowledge |

## Verification
A write-back write hit does two things in the same cycle: it sets the line's dirty bit and it moves the set's USE bit to that way. If either update is dropped, the error is silent until a later miss in that set. The bench provokes this with a directed run in one set. It writes to one resident line and then misses twice. The first miss must evict the other, clean way with no memory write. The second must evict the written line and write its new word to memory. Both the traffic counts and the memory contents are checked against expected values. A long random run of mixed policies then compares every read against a model of memory, and a final clean-and-discard must leave memory equal to that model.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_LOOKUP, S_EVICT, S_FILL, S_MWR, S_MRD, S_SCAN, S_SCAN_WR
  } cst_e;
endpackage

// File: rtl/cache2w_tags.sv
module cache2w_tags #(
  parameter int SET_W = 4,
  parameter int TAG_W = 18
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [SET_W-1:0]      set_i,
  input  logic [TAG_W-1:0]      tag_i,
  output logic                  hit_o,
  output logic                  hit_way_o,
  output logic                  vict_way_o,
  output logic [1:0]            way_valid_o,
  output logic [1:0]            way_dirty_o,
  output logic [1:0][TAG_W-1:0] way_tag_o,
  input  logic                  upd_i,
  input  logic                  upd_way_i,
  input  logic [TAG_W-1:0]      upd_tag_i,
  input  logic                  upd_dirty_i,
  input  logic                  touch_i,
  input  logic                  touch_way_i,
  input  logic                  clear_i
);
  localparam int NSETS = 1 << SET_W;

  logic [TAG_W-1:0] tag_q   [NSETS][2];
  logic [1:0]       valid_q [NSETS];
  logic [1:0]       dirty_q [NSETS];
  logic [1:0]       use_q   [NSETS];
  logic [1:0]       match;

  for (genvar w = 0; w < 2; w++) begin : g_way
    assign way_tag_o[w] = tag_q[set_i][w];
    assign match[w]     = valid_q[set_i][w] && (tag_q[set_i][w] == tag_i);
  end

  assign way_valid_o = valid_q[set_i];
  assign way_dirty_o = dirty_q[set_i];
  assign hit_o       = |match;
  assign hit_way_o   = match[1];
  // invalid way 0 first, then invalid way 1, then the way with USE clear
  assign vict_way_o  = valid_q[set_i][0] & (~valid_q[set_i][1] | use_q[set_i][0]);

  always_ff @(posedge clk_i) begin
    if (upd_i) tag_q[set_i][upd_way_i] <= upd_tag_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NSETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
        use_q[s]   <= '0;
      end
    end else begin
      if (clear_i) begin
        for (int s = 0; s < NSETS; s++) begin
          valid_q[s] <= '0;
          dirty_q[s] <= '0;
        end
      end else if (upd_i) begin
        valid_q[set_i][upd_way_i] <= 1'b1;
        dirty_q[set_i][upd_way_i] <= upd_dirty_i;
      end
      if (touch_i) begin
        use_q[set_i][touch_way_i]  <= 1'b1;
        use_q[set_i][!touch_way_i] <= 1'b0;
      end
    end
  end

  AST_NO_DUP_TAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_q[set_i][0] && valid_q[set_i][1] && tag_q[set_i][0] == tag_q[set_i][1])); // R2
  AST_INV_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> way_valid_o == 2'b00); // R9
endmodule

// File: rtl/cache2w_data.sv
module cache2w_data #(
  parameter int SET_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic                   clk_i,
  input  logic [SET_W-1:0]       set_i,
  output logic [1:0][DATA_W-1:0] rdata_o,
  input  logic                   we_i,
  input  logic                   way_i,
  input  logic [DATA_W-1:0]      wdata_i
);
  localparam int NSETS = 1 << SET_W;

  logic [DATA_W-1:0] line_q [NSETS][2];

  for (genvar w = 0; w < 2; w++) begin : g_rd
    assign rdata_o[w] = line_q[set_i][w];
  end

  always_ff @(posedge clk_i) begin
    if (we_i) line_q[set_i][way_i] <= wdata_i;
  end
endmodule

// File: rtl/cache2w_ctrl.sv
module cache2w_ctrl
  import cache2w_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int SET_W  = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_i,
  input  logic                      we_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [DATA_W-1:0]         wdata_i,
  input  logic                      nwt_i,
  input  logic                      cd_i,
  input  logic                      inv_i,
  input  logic                      flush_i,
  output logic                      ready_o,
  output logic                      ack_o,
  output logic [DATA_W-1:0]         rdata_o,
  output logic                      mem_req_o,
  output logic                      mem_we_o,
  output logic [ADDR_W-3:0]         mem_addr_o,
  output logic [DATA_W-1:0]         mem_wdata_o,
  input  logic [DATA_W-1:0]         mem_rdata_i,
  input  logic                      mem_ack_i
);
  localparam int OFF_W = 2;
  localparam int BLK_W = ADDR_W - OFF_W;
  localparam int TAG_W = BLK_W - SET_W;

  cst_e st_q, st_d;
  logic [BLK_W-1:0]  blk_q;
  logic              we_q, nwt_q, cd_q, vict_q, vict_d, ack_q, ack_d;
  logic [DATA_W-1:0] wdata_q, rdata_q, rdata_d;
  logic [SET_W:0]    scan_q, scan_d;

  logic                  hit, hit_way, vict_way;
  logic [1:0]            way_valid, way_dirty;
  logic [1:0][TAG_W-1:0] way_tag;
  logic [1:0][DATA_W-1:0] line_rd;
  logic                  tag_upd, upd_way, upd_dirty, touch, touch_way, clr;
  logic                  dat_we, dat_way;
  logic [DATA_W-1:0]     dat_wdata;
  logic                  scanning;
  logic [SET_W-1:0]      idx_set;
  logic                  unused_off;

  assign unused_off = ^addr_i[OFF_W-1:0]; // word port: offset selects nothing
  assign scanning   = (st_q == S_SCAN) || (st_q == S_SCAN_WR);
  assign idx_set    = scanning ? scan_q[SET_W:1] : blk_q[SET_W-1:0];

  cache2w_tags #(.SET_W(SET_W), .TAG_W(TAG_W)) u_tags (
    .clk_i, .rst_ni, .set_i(idx_set), .tag_i(blk_q[BLK_W-1:SET_W]),
    .hit_o(hit), .hit_way_o(hit_way), .vict_way_o(vict_way),
    .way_valid_o(way_valid), .way_dirty_o(way_dirty), .way_tag_o(way_tag),
    .upd_i(tag_upd), .upd_way_i(upd_way), .upd_tag_i(blk_q[BLK_W-1:SET_W]),
    .upd_dirty_i(upd_dirty), .touch_i(touch), .touch_way_i(touch_way), .clear_i(clr)
  );

  cache2w_data #(.SET_W(SET_W), .DATA_W(DATA_W)) u_data (
    .clk_i, .set_i(idx_set), .rdata_o(line_rd),
    .we_i(dat_we), .way_i(dat_way), .wdata_i(dat_wdata)
  );

  always_comb begin
    st_d = st_q;  vict_d = vict_q;  scan_d = scan_q;
    ack_d = 1'b0; rdata_d = rdata_q;
    tag_upd = 1'b0; upd_way = hit_way; upd_dirty = 1'b0;
    touch = 1'b0; touch_way = hit_way; clr = 1'b0;
    dat_we = 1'b0; dat_way = hit_way; dat_wdata = wdata_q;
    mem_req_o = 1'b0; mem_we_o = 1'b0; mem_addr_o = blk_q; mem_wdata_o = wdata_q;
    unique case (st_q)
      S_IDLE: begin
        if (flush_i) begin scan_d = '0; st_d = S_SCAN; end
        else if (inv_i) clr = 1'b1;
        else if (req_i) st_d = S_LOOKUP;
      end
      S_LOOKUP: begin
        if (cd_q) st_d = we_q ? S_MWR : S_MRD;
        else if (hit) begin
          touch = 1'b1;
          if (we_q) begin
            dat_we = 1'b1;
            if (nwt_q) begin
              tag_upd = 1'b1; upd_dirty = 1'b1; ack_d = 1'b1; st_d = S_IDLE;
            end else st_d = S_MWR;
          end else begin
            rdata_d = line_rd[hit_way]; ack_d = 1'b1; st_d = S_IDLE;
          end
        end else if (we_q && !nwt_q) st_d = S_MWR;
        else begin
          vict_d = vict_way;
          st_d = (way_valid[vict_way] && way_dirty[vict_way]) ? S_EVICT : S_FILL;
        end
      end
      S_EVICT: begin
        mem_req_o = 1'b1; mem_we_o = 1'b1;
        mem_addr_o = {way_tag[vict_q], blk_q[SET_W-1:0]};
        mem_wdata_o = line_rd[vict_q];
        if (mem_ack_i) st_d = S_FILL;
      end
      S_FILL: begin
        mem_req_o = 1'b1;
        if (mem_ack_i) begin
          tag_upd = 1'b1; upd_way = vict_q; upd_dirty = we_q;
          touch = 1'b1; touch_way = vict_q;
          dat_we = 1'b1; dat_way = vict_q;
          dat_wdata = we_q ? wdata_q : mem_rdata_i;
          rdata_d = mem_rdata_i; ack_d = 1'b1; st_d = S_IDLE;
        end
      end
      S_MWR: begin
        mem_req_o = 1'b1; mem_we_o = 1'b1;
        if (mem_ack_i) begin ack_d = 1'b1; st_d = S_IDLE; end
      end
      S_MRD: begin
        mem_req_o = 1'b1;
        if (mem_ack_i) begin rdata_d = mem_rdata_i; ack_d = 1'b1; st_d = S_IDLE; end
      end
      S_SCAN: begin
        if (way_valid[scan_q[0]] && way_dirty[scan_q[0]]) st_d = S_SCAN_WR;
        else if (&scan_q) begin clr = 1'b1; st_d = S_IDLE; end
        else scan_d = scan_q + 1'b1;
      end
      S_SCAN_WR: begin
        mem_req_o = 1'b1; mem_we_o = 1'b1;
        mem_addr_o = {way_tag[scan_q[0]], scan_q[SET_W:1]};
        mem_wdata_o = line_rd[scan_q[0]];
        if (mem_ack_i) begin
          if (&scan_q) begin clr = 1'b1; st_d = S_IDLE; end
          else begin scan_d = scan_q + 1'b1; st_d = S_SCAN; end
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE; blk_q <= '0; we_q <= 1'b0; nwt_q <= 1'b0; cd_q <= 1'b0;
      wdata_q <= '0; rdata_q <= '0; ack_q <= 1'b0; vict_q <= 1'b0; scan_q <= '0;
    end else begin
      st_q <= st_d; vict_q <= vict_d; scan_q <= scan_d;
      ack_q <= ack_d; rdata_q <= rdata_d;
      if (st_q == S_IDLE && st_d == S_LOOKUP) begin
        blk_q <= addr_i[ADDR_W-1:OFF_W]; we_q <= we_i; wdata_q <= wdata_i;
        nwt_q <= nwt_i; cd_q <= cd_i;
      end
    end
  end

  assign ready_o = (st_q == S_IDLE);
  assign ack_o   = ack_q;
  assign rdata_o = rdata_q;

  AST_MEM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)
                                && $stable(mem_wdata_o)); // R4
  AST_EVICT_DIRTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == S_EVICT |-> way_valid[vict_q] && way_dirty[vict_q]); // R6
  AST_WT_NO_DIRTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_upd && upd_dirty |-> nwt_q); // R7
  AST_CD_NO_ALLOC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == S_LOOKUP && cd_q |-> !tag_upd && !touch && !dat_we); // R8
  AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !ready_o); // R12
  AST_ACK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o); // R3
endmodule

// File: tb/tb_cache2w_ctrl.sv
module tb_cache2w_ctrl;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 24;
  localparam int DATA_W = 32;
  localparam int SET_W  = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 0, we = 0, nwt = 1, cd = 0, inv = 0, flush = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0, rdata;
  logic ready, ack;
  logic mem_req, mem_we, mem_ack = 0;
  logic [ADDR_W-3:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata, mem_rdata = '0;

  cache2w_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SET_W(SET_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .nwt_i(nwt), .cd_i(cd), .inv_i(inv), .flush_i(flush), .ready_o(ready), .ack_o(ack),
    .rdata_o(rdata), .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack)
  );

  always #(CLK_P/2) clk = ~clk;

  logic [31:0] mem [128];
  logic [31:0] ref_mem [128];
  int rd_cnt = 0, wr_cnt = 0, dly = 0;
  int n_chk = 0, n_fail = 0;
  logic busy_s;
  bit done = 0;

  // memory model: acknowledges after 0..2 idle cycles
  always @(negedge clk) begin
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      if (dly == 0) begin
        mem_ack = 1'b1;
        if (mem_we) begin mem[mem_addr[6:0]] = mem_wdata; wr_cnt++; end
        else begin mem_rdata = mem[mem_addr[6:0]]; rd_cnt++; end
        dly = int'($urandom % 3);
      end else dly--;
    end
  end

  function automatic logic [ADDR_W-1:0] ad(int t, int s);
    return ADDR_W'(t * 64 + s * 4);
  endfunction

  function automatic int bi(int t, int s);
    return t * 16 + s;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [ADDR_W-1:0] a, input logic [31:0] d,
                     output logic [31:0] r);
    @(negedge clk);
    while (!ready) @(negedge clk);
    req = 1; we = w; addr = a; wdata = d;
    @(negedge clk);
    req = 0; busy_s = ready;
    while (!ack) @(negedge clk);
    r = rdata;
  endtask

  task automatic cmd(input logic fl);
    @(negedge clk);
    while (!ready) @(negedge clk);
    if (fl) flush = 1; else inv = 1;
    @(negedge clk);
    flush = 0; inv = 0;
    while (!ready) @(negedge clk);
  endtask

  int r0, w0;
  task automatic snap();
    r0 = rd_cnt; w0 = wr_cnt;
  endtask
  task automatic traffic(string tag, int er, int ew);
    chk({tag, " mem reads"}, 32'(rd_cnt - r0), 32'(er));
    chk({tag, " mem writes"}, 32'(wr_cnt - w0), 32'(ew));
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd4242));
    for (int i = 0; i < 128; i++) mem[i] = 32'hA000_0000 + i;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 ready after reset", 32'(ready), 32'd1);
    chk("R12 no mem req after reset", 32'(mem_req), 32'd0);
    rst_n = 1;
    nwt = 1; cd = 0;

    // R4 read miss, R12 busy
    snap(); acc(0, ad(0,3), 0, r);
    chk("R4 miss data", r, 32'hA000_0003); traffic("R4 miss", 1, 0);
    chk("R12 not ready while busy", 32'(busy_s), 32'd0);
    // R1 offset bits ignored, R3 hit
    snap(); acc(0, ad(0,3) | 24'd2, 0, r);
    chk("R1 offset same line", r, 32'hA000_0003); traffic("R3 hit", 0, 0);
    // R2 both ways resident
    snap(); acc(0, ad(1,3), 0, r); chk("R2 second way data", r, mem[bi(1,3)]);
    acc(0, ad(0,3), 0, r); traffic("R2 A and B fill only", 1, 0);
    snap(); acc(0, ad(1,3), 0, r); traffic("R2 B still resident", 0, 0);
    acc(0, ad(0,3), 0, r);
    // R5 LRU: C evicts B
    snap(); acc(0, ad(2,3), 0, r); traffic("R5 C fill clean victim", 1, 0);
    snap(); acc(0, ad(0,3), 0, r); traffic("R5 recent A kept", 0, 0);
    snap(); acc(0, ad(1,3), 0, r); traffic("R5 LRU B evicted", 1, 0);
    // R6 write-back hit
    snap(); acc(1, ad(0,3), 32'h1111, r); traffic("R6 wb write hit", 0, 0);
    chk("R6 memory untouched", mem[bi(0,3)], 32'hA000_0003);
    snap(); acc(0, ad(0,3), 0, r); chk("R6 cached new word", r, 32'h1111);
    acc(0, ad(2,3), 0, r); traffic("R6 clean victim no write", 1, 0);
    snap(); acc(0, ad(3,3), 0, r); traffic("R6 dirty victim written", 1, 1);
    chk("R6 written-back word", mem[bi(0,3)], 32'h1111);
    // R11 write-back write miss allocates
    snap(); acc(1, ad(0,5), 32'h2222, r); traffic("R11 wb write miss", 1, 0);
    snap(); acc(0, ad(0,5), 0, r); chk("R11 merged word", r, 32'h2222);
    traffic("R11 allocated", 0, 0);
    // R7 write-through
    nwt = 0;
    snap(); acc(1, ad(0,5), 32'h3333, r); traffic("R7 wt write hit", 0, 1);
    chk("R7 memory updated", mem[bi(0,5)], 32'h3333);
    snap(); acc(0, ad(0,5), 0, r); chk("R7 cache updated", r, 32'h3333);
    traffic("R7 read after wt hit", 0, 0);
    snap(); acc(1, ad(1,6), 32'h4444, r); traffic("R11 wt write miss", 0, 1);
    snap(); acc(0, ad(1,6), 0, r); chk("R11 wt miss data", r, 32'h4444);
    traffic("R11 wt no allocate", 1, 0);
    // R8 bypass
    nwt = 1;
    acc(1, ad(0,7), 32'h5555, r);
    cd = 1;
    snap(); acc(0, ad(0,7), 0, r); chk("R8 bypass read memory", r, 32'hA000_0007);
    traffic("R8 bypass read", 1, 0);
    snap(); acc(1, ad(0,8), 32'h6666, r); traffic("R8 bypass write", 0, 1);
    cd = 0;
    snap(); acc(0, ad(0,8), 0, r); chk("R8 bypass no alloc data", r, 32'h6666);
    traffic("R8 bypass no alloc", 1, 0);
    snap(); acc(0, ad(0,7), 0, r); chk("R8 cache unaffected", r, 32'h5555);
    // R9 invalidate discards
    snap(); cmd(0); traffic("R9 invalidate", 0, 0);
    snap(); acc(0, ad(0,7), 0, r); chk("R9 dirty word lost", r, 32'hA000_0007);
    traffic("R9 miss after invalidate", 1, 0);
    // R10 flush
    acc(1, ad(0,9), 32'h7777, r);
    acc(1, ad(1,9), 32'h8888, r);
    snap(); cmd(1); traffic("R10 flush", 0, 2);
    chk("R10 line 0 written", mem[bi(0,9)], 32'h7777);
    chk("R10 line 1 written", mem[bi(1,9)], 32'h8888);
    snap(); acc(0, ad(0,9), 0, r); chk("R10 data after flush", r, 32'h7777);
    traffic("R10 invalid after flush", 1, 0);

    // random mix against a memory model
    for (int i = 0; i < 128; i++) ref_mem[i] = mem[i];
    for (int n = 0; n < 600; n++) begin
      int t, s; logic w; logic [31:0] d;
      t = int'($urandom % 4); s = int'($urandom % 16);
      w = 1'($urandom % 2); d = $urandom;
      nwt = 1'($urandom % 2);
      acc(w, ad(t, s), d, r);
      if (w) ref_mem[bi(t, s)] = d;
      else chk("R3 random read", r, ref_mem[bi(t, s)]);
    end
    cmd(1);
    for (int i = 0; i < 128; i++) chk("R10 final memory", mem[i], ref_mem[i]);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule